// File: doc/BRIEF.md
# GPIO and Interrupt Expander

This block adds general-purpose pins to a host processor and merges a group of interrupt sources into one upstream interrupt line. The host reaches it over a simple parallel bus: a byte address, a one-cycle write strobe and write data. The address is registered and the read data is decoded from that registered address without further delay. A bank of pin registers holds the output pin levels and shows the input pin levels. Each pin's direction is fixed when the block is built.

A separate status register shows which interrupt sources are pending. A source becomes pending on a rising edge of its synchronized input, and it stays pending until the host writes the clearing pattern to that register. No per-source mask exists, so every pending source drives the upstream line. The host sees that line as edge-signalled. For this reason the line is held low for one cycle after every clear. A source that is still pending then gives the host a new rising edge.

A synchronous reset models power returning to the expander. The output pins come back at their build-time reset levels and no source is pending.

Top module: `gpio_irq_expander`

## Requirements
- R1: While reset is asserted and after it is released, pin_out equals RESET_VAL on output pins and 0 on input pins, no source is pending and irq_out is 0.
- R2: The register index is bus_addr shifted right by 1 for a 16-bit bus or by 2 for a 32-bit bus. The low address bits below that shift have no effect on reads.
- R3: Pin n belongs to register index PIN_BASE + n / REG_W, at bit n mod REG_W of the data. A write to that register updates pin_out on the second rising clock edge after the strobe is presented.
- R4: Reading a pin register returns, for each output pin, the last value written to it. Bits that map to no pin read 0.
- R5: Reading a pin register returns, for each input pin, pin_in after a two-flop synchronizer. Writes never change the pin_out bit of an input pin, which stays 0.
- R6: An index that is neither the status register nor a pin register reads as 0, and writes to it change no pin and no pending bit.
- R7: A rising edge on a synchronized irq_src bit sets a sticky pending bit. Reading index ACK_IDX returns the pending bits in data bits [NUM_IRQ-1:0], with zeros above them. A pending bit stays set after its source falls or stays high.
- R8: A write to ACK_IDX whose data bits [15:0] equal 16'hFFFF (INV_ACK=0) or 16'h0000 (INV_ACK=1) clears all pending bits. A write of any other value has no effect.
- R9: A source edge that would set its pending bit on the same clock edge as the clear stays pending.
- R10: irq_out is the registered OR of all pending bits, with no per-source masking. It is forced to 0 for the one cycle after a clear and rises again if any bit is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up restore) |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | BUS_W | Host write data |
| bus_rdata | output | BUS_W | Read data for the registered address |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output pin levels |
| irq_src | input | NUM_IRQ | Asynchronous interrupt sources |
| irq_out | output | 1 | Upstream interrupt line |

## Verification
Read data is valid in the cycle after the address is presented. A write changes pin_out and its read-back two edges after the strobe. An input pin shows in the read data two edges after it changes. A source edge sets its pending bit three edges after the source rises, and irq_out follows one edge after that. The bench drives every input on the falling edge. It samples outputs only on a later falling edge, counted to these latencies. The clear-collision test places the source edge exactly one cycle before the write strobe, so that its pending bit is set on the same edge as the clear. The bench then checks irq_out cycle by cycle as it goes low and then high.

// File: rtl/exp_pkg.sv
package exp_pkg;
  localparam logic [15:0] CLEAR_ONES  = 16'hFFFF;
  localparam logic [15:0] CLEAR_ZEROS = 16'h0000;

  function automatic int addr_shift(input int bus_w);
    return (bus_w == 32) ? 2 : 1;
  endfunction

  function automatic int reg_count(input int pins, input int reg_w);
    return (pins + reg_w - 1) / reg_w;
  endfunction
endpackage

// File: rtl/exp_bus_front.sv
module exp_bus_front #(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 8,
  localparam int SH    = exp_pkg::addr_shift(BUS_W),
  localparam int IDX_W = ADDR_W - SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              wr_q,
  output logic [BUS_W-1:0]  wdata_q
);
  logic unused_low;
  assign unused_low = ^bus_addr[SH-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      idx_q   <= bus_addr[ADDR_W-1:SH];
      wr_q    <= bus_wr;
      wdata_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/exp_pin_bank.sv
module exp_pin_bank #(
  parameter int REG_W    = 8,
  parameter int NUM_PINS = 20,
  parameter int IDX_W    = 7,
  parameter int PIN_BASE = 2,
  parameter logic [NUM_PINS-1:0] DIR_OUT   = '0,
  parameter logic [NUM_PINS-1:0] RESET_VAL = '0,
  localparam int NREG = exp_pkg::reg_count(NUM_PINS, REG_W),
  localparam int PADW = NREG * REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    idx_q,
  input  logic                wr_q,
  input  logic [REG_W-1:0]    wdata_q,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [REG_W-1:0]    rd_data,
  output logic                hit
);
  logic [31:0]         idx32, rel;
  logic [NREG-1:0]     we;
  logic [NUM_PINS-1:0] sync1, sync2;
  logic [PADW-1:0]     view;
  logic                unused_sync;

  assign idx32 = 32'(idx_q);
  assign rel   = idx32 - 32'(PIN_BASE);
  assign hit   = (idx32 >= 32'(PIN_BASE)) && (rel < 32'(NREG));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end
  assign unused_sync = ^sync2;

  for (genvar r = 0; r < NREG; r++) begin : g_we
    assign we[r] = wr_q && hit && (rel == 32'(r));
  end

  for (genvar n = 0; n < PADW; n++) begin : g_pin
    if (n >= NUM_PINS) begin : g_pad
      assign view[n] = 1'b0;
    end else if (DIR_OUT[n]) begin : g_out
      logic q;
      always_ff @(posedge clk) begin
        if (rst)                q <= RESET_VAL[n];
        else if (we[n / REG_W]) q <= wdata_q[n % REG_W];
      end
      assign pin_out[n] = q;
      assign view[n]    = q;
    end else begin : g_in
      assign pin_out[n] = 1'b0;
      assign view[n]    = sync2[n];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hit && rel == 32'(r)) rd_data = view[r*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/exp_irq_collect.sv
module exp_irq_collect #(
  parameter int NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_src,
  input  logic               ack_fire,
  output logic [NUM_IRQ-1:0] pending,
  output logic               irq_out
);
  logic [NUM_IRQ-1:0] s1, s2, s3, rise;

  assign rise = s2 & ~s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= '0;
      s2      <= '0;
      s3      <= '0;
      pending <= '0;
      irq_out <= 1'b0;
    end else begin
      s1      <= irq_src;
      s2      <= s1;
      s3      <= s2;
      pending <= (ack_fire ? '0 : pending) | rise;
      irq_out <= ack_fire ? 1'b0 : (|pending);
    end
  end
endmodule

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander #(
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int REG_W    = 8,
  parameter int NUM_PINS = 20,
  parameter int PIN_BASE = 2,
  parameter int ACK_IDX  = 1,
  parameter int NUM_IRQ  = 6,
  parameter bit INV_ACK  = 1'b0,
  parameter logic [NUM_PINS-1:0] DIR_OUT   = 20'hF0F3C,
  parameter logic [NUM_PINS-1:0] RESET_VAL = 20'hA5A5A,
  localparam int SH    = exp_pkg::addr_shift(BUS_W),
  localparam int IDX_W = ADDR_W - SH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  input  logic [NUM_IRQ-1:0]  irq_src,
  output logic                irq_out
);
  localparam logic [15:0] CLEAR_VAL = INV_ACK ? exp_pkg::CLEAR_ZEROS : exp_pkg::CLEAR_ONES;

  logic [IDX_W-1:0]   idx_q;
  logic               wr_q;
  logic [BUS_W-1:0]   wdata_q;
  logic [REG_W-1:0]   pin_rd;
  logic               pin_hit;
  logic               ack_hit;
  logic               ack_fire;
  logic [NUM_IRQ-1:0] pending;
  logic               unused_wd;

  exp_bus_front #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_front (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .idx_q(idx_q), .wr_q(wr_q), .wdata_q(wdata_q)
  );

  exp_pin_bank #(
    .REG_W(REG_W), .NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .PIN_BASE(PIN_BASE),
    .DIR_OUT(DIR_OUT), .RESET_VAL(RESET_VAL)
  ) u_pins (
    .clk(clk), .rst(rst), .idx_q(idx_q), .wr_q(wr_q),
    .wdata_q(wdata_q[REG_W-1:0]), .pin_in(pin_in), .pin_out(pin_out),
    .rd_data(pin_rd), .hit(pin_hit)
  );

  assign ack_hit  = (32'(idx_q) == 32'(ACK_IDX));
  assign ack_fire = wr_q && ack_hit && (wdata_q[15:0] == CLEAR_VAL);
  assign unused_wd = ^wdata_q;

  exp_irq_collect #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst(rst), .irq_src(irq_src), .ack_fire(ack_fire),
    .pending(pending), .irq_out(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (ack_hit)      bus_rdata[NUM_IRQ-1:0] = pending;
    else if (pin_hit) bus_rdata[REG_W-1:0]   = pin_rd;
  end
endmodule

// File: rtl/exp_checker.sv
module exp_checker #(
  parameter int NUM_PINS = 20,
  parameter int NUM_IRQ  = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_q,
  input logic                ack_fire,
  input logic [NUM_IRQ-1:0]  pending,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] pin_out
);
  assert_pins_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_q |=> $stable(pin_out));

  assert_pending_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !ack_fire |=> ((pending & $past(pending)) == $past(pending)));

  assert_irq_gap_R10: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> !irq_out);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(pending != '0));

  assert_irq_unmasked_R10: assert property (@(posedge clk) disable iff (rst)
    (pending != '0 && !ack_fire) |=> irq_out);
endmodule

bind gpio_irq_expander exp_checker #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .wr_q(wr_q), .ack_fire(ack_fire),
  .pending(pending), .irq_out(irq_out), .pin_out(pin_out)
);

// File: tb/tb_gpio_irq_expander.sv
module tb_gpio_irq_expander;
  localparam int BUS_W = 16, ADDR_W = 8, REG_W = 8, NUM_PINS = 20;
  localparam int PIN_BASE = 2, ACK_IDX = 1, NUM_IRQ = 6, NREG = 3;
  localparam logic [NUM_PINS-1:0] DIR_OUT   = 20'hF0F3C;
  localparam logic [NUM_PINS-1:0] RESET_VAL = 20'hA5A5A;

  logic clk = 1'b0, rst = 1'b1;
  logic [ADDR_W-1:0]   bus_addr = '0;
  logic                bus_wr = 1'b0;
  logic [BUS_W-1:0]    bus_wdata = '0;
  logic [BUS_W-1:0]    bus_rdata;
  logic [NUM_PINS-1:0] pin_in = '0;
  logic [NUM_PINS-1:0] pin_out;
  logic [NUM_IRQ-1:0]  irq_src = '0;
  logic                irq_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [NUM_PINS-1:0] shadow;
  logic [NUM_IRQ-1:0]  pend_m;

  always #4 clk = ~clk;

  gpio_irq_expander #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_PINS(NUM_PINS),
    .PIN_BASE(PIN_BASE), .ACK_IDX(ACK_IDX), .NUM_IRQ(NUM_IRQ), .INV_ACK(1'b0),
    .DIR_OUT(DIR_OUT), .RESET_VAL(RESET_VAL)
  ) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq_src(irq_src), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_write(input int idx, input logic [15:0] data);
    @(negedge clk);
    bus_addr  = ADDR_W'(idx << 1);
    bus_wr    = 1'b1;
    bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] addr, output logic [15:0] data);
    @(negedge clk);
    bus_addr = addr;
    @(negedge clk);
    @(negedge clk);
    data = bus_rdata;
  endtask

  function automatic logic [15:0] expect_reg(input int idx);
    logic [15:0] v = '0;
    if (idx == ACK_IDX) v[NUM_IRQ-1:0] = pend_m;
    else if (idx >= PIN_BASE && idx < PIN_BASE + NREG) begin
      for (int b = 0; b < REG_W; b++) begin
        int n = (idx - PIN_BASE) * REG_W + b;
        if (n < NUM_PINS) v[b] = DIR_OUT[n] ? shadow[n] : pin_in[n];
      end
    end
    return v;
  endfunction

  function automatic void model_write(input int idx, input logic [15:0] data);
    if (idx >= PIN_BASE && idx < PIN_BASE + NREG) begin
      for (int b = 0; b < REG_W; b++) begin
        int n = (idx - PIN_BASE) * REG_W + b;
        if (n < NUM_PINS && DIR_OUT[n]) shadow[n] = data[b];
      end
    end
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      report();
    end
  end

  initial begin
    logic [15:0] rd, rd2;
    shadow = RESET_VAL & DIR_OUT;
    pend_m = '0;
    repeat (3) @(negedge clk);
    check("R1 pin_out during reset", 32'(pin_out), 32'(shadow));
    check("R1 irq_out during reset", 32'(irq_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pin_out after reset", 32'(pin_out), 32'(shadow));
    bus_read(ADDR_W'(ACK_IDX << 1), rd);
    check("R1 no pending after reset", 32'(rd), 0);

    // R3 R4 R5 R6: sweep writes over indices, read back every index
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk);
      pin_in = (pass == 0) ? 20'h3C96A : 20'hC3695;
      for (int w = 0; w < 16; w++) begin
        logic [15:0] pat;
        if (w == ACK_IDX) continue;
        pat = 16'(16'hA5C3 ^ (w * 16'h1357) ^ (pass * 16'hFFFF));
        bus_write(w, pat);
        model_write(w, pat);
        @(negedge clk);
        check("R3 R5 R6 pin_out after write", 32'(pin_out), 32'(shadow));
        for (int r = 0; r < 16; r++) begin
          bus_read(ADDR_W'(r << 1), rd);
          check("R4 R5 R6 register read", 32'(rd), 32'(expect_reg(r)));
        end
      end
    end

    // R2: low address bit ignored
    for (int r = 0; r < 8; r++) begin
      bus_read(ADDR_W'(r << 1), rd);
      bus_read(ADDR_W'((r << 1) | 1), rd2);
      check("R2 low address bit ignored", 32'(rd2), 32'(rd));
    end

    // R7: rising edge sets sticky pending
    @(negedge clk);
    bus_addr = ADDR_W'(ACK_IDX << 1);
    irq_src[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 not pending before third edge", 32'(bus_rdata), 0);
    @(negedge clk);
    pend_m = 6'h04;
    check("R7 pending after third edge", 32'(bus_rdata), 32'(pend_m));
    check("R10 irq_out not yet high", 32'(irq_out), 0);
    @(negedge clk);
    check("R10 irq_out follows pending", 32'(irq_out), 1);
    irq_src[2] = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 pending sticky after source falls", 32'(bus_rdata), 32'(pend_m));

    // R8: non-clearing values
    bus_write(ACK_IDX, 16'h00FF);
    bus_write(ACK_IDX, 16'h0000);
    bus_read(ADDR_W'(ACK_IDX << 1), rd);
    check("R8 non-clearing write ignored", 32'(rd), 32'(pend_m));
    check("R8 irq_out stays high", 32'(irq_out), 1);
    // R6: write to unmapped index leaves pending
    bus_write(9, 16'hFFFF);
    bus_read(ADDR_W'(ACK_IDX << 1), rd);
    check("R6 unmapped write leaves pending", 32'(rd), 32'(pend_m));

    // R8: clearing value
    bus_write(ACK_IDX, 16'hFFFF);
    @(negedge clk);
    pend_m = '0;
    check("R8 clear empties pending", 32'(bus_rdata), 0);
    check("R8 irq_out low after clear", 32'(irq_out), 0);

    // R7 R10: two sources together, then level held does not re-pend
    @(negedge clk);
    irq_src = 6'h21;
    repeat (4) @(negedge clk);
    pend_m = 6'h21;
    check("R7 two sources pending", 32'(bus_rdata), 32'(pend_m));
    check("R10 irq_out for two sources", 32'(irq_out), 1);
    bus_write(ACK_IDX, 16'hFFFF);
    repeat (4) @(negedge clk);
    pend_m = '0;
    check("R7 held level does not re-pend", 32'(bus_rdata), 0);
    check("R10 irq_out low with none pending", 32'(irq_out), 0);
    irq_src = '0;
    repeat (4) @(negedge clk);

    // R9: edge on the clearing edge survives; irq_out drops one cycle
    irq_src[1] = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 irq_out before collision", 32'(irq_out), 1);
    irq_src[3] = 1'b1;
    @(negedge clk);
    bus_addr  = ADDR_W'(ACK_IDX << 1);
    bus_wr    = 1'b1;
    bus_wdata = 16'hFFFF;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 irq_out high before clear edge", 32'(irq_out), 1);
    @(negedge clk);
    pend_m = 6'h08;
    check("R9 collided edge stays pending", 32'(bus_rdata), 32'(pend_m));
    check("R10 irq_out forced low", 32'(irq_out), 0);
    @(negedge clk);
    check("R10 irq_out rises again", 32'(irq_out), 1);

    // R1: reset restores outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    shadow = RESET_VAL & DIR_OUT;
    check("R1 pin_out restored", 32'(pin_out), 32'(shadow));
    check("R1 irq_out cleared", 32'(irq_out), 0);

    done = 1'b1;
    report();
  end
endmodule